// File: doc/BRIEF.md
# Serial Bus Controller Register Front End

This block is the CPU-facing register layer of a byte-oriented two-wire serial bus controller (I2C). Software drives the controller through four byte-wide locations: a flag register written with set semantics, a matching location written with clear semantics, a read-only status byte and a data byte. The bit-level serial engine sits on the other side of the block. It posts status codes, and it moves the data byte one bit per strobe, most significant bit first, while the interrupt flag is low.

The serial engine moves one bit per strobe, so the core side carries no byte stream and no back-pressure. Its pins are plain control strobes. A posted status code other than the idle code raises the interrupt flag. Posting the idle code lowers that flag. While the interrupt flag is high the data byte belongs to software: the engine cannot shift it, and software may read and write it freely. While the flag is low, CPU writes to the data byte are dropped and CPU reads return the byte as it stood when the flag was last high.

Address map (2-bit address): 0 = flag set / flag read, 1 = status, 2 = data, 3 = flag clear. Flag positions are the same in the set and clear locations: bit 2 = acknowledge-assert, bit 3 = interrupt (SI), bit 5 = start, bit 6 = interface enable. Bits 0, 1, 4 and 7 are reserved.

Top module: `serctl_regfile`

## Requirements
- R1: After reset the flag register reads 0x00, the status byte reads 0xF8 (code 0x1F) and the data byte reads 0x00.
- R2: A write to address 0 with a 1 in bit 2, 3, 5 or 6 sets that flag. A 0 in any bit leaves its flag unchanged. The SI bit is set this way only while the status code is not 0x1F.
- R3: A write to address 3 with a 1 in bit 2, 3, 5 or 6 clears that flag, and a 0 leaves it unchanged.
- R4: Reserved bits 0, 1, 4 and 7 of the flag register always read 0, and writes to them have no effect.
- R5: The status byte at address 1 always reads as the last posted 5-bit code in bits 7:3, with bits 2:0 at 0. CPU writes to address 1 have no effect.
- R6: Posting any code other than 0x1F sets SI on the next clock. Posting 0x1F clears SI.
- R7: When the core posts a non-idle code in the same cycle as a CPU write that clears SI, SI ends up set.
- R8: While SI is set, a CPU write to address 2 loads the data byte and a read returns it. While SI is clear, writes to address 2 are ignored and reads return the value held when SI was last set.
- R9: While SI is set, the shift strobe has no effect and the data byte stays unchanged unless the CPU writes it.
- R10: While SI is clear, each shift strobe moves the data byte one place toward bit 7 and loads the serial input into bit 0. The serial output always shows bit 7, so a byte leaves MSB first and a received byte finishes with its first bit in bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 2 | Register address |
| cpu_we | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for cpu_addr (combinational) |
| core_post | input | 1 | Core posts a new status code |
| core_code | input | 5 | Status code posted with core_post |
| core_shift | input | 1 | Shift strobe for the data byte |
| core_sin | input | 1 | Serial bit shifted into bit 0 |
| core_sout | output | 1 | Bit 7 of the data byte |
| irq_flag | output | 1 | Current SI flag |

## Verification
The bench builds the block with its default parameters: an 8-bit byte, a 5-bit code and a 0x1F idle code. With these values every case can be swept. All 256 write values are applied to both the set and clear locations from a known flag state. Every one of the 32 status codes is posted and read back. Full bytes are shifted out and in, one bit at a time. This covers every reserved bit and every code, and the bench computes each expected byte arithmetically from the flag mask and the shift rule.

// File: rtl/serctl_pkg.sv
package serctl_pkg;
  localparam int BYTE_W = 8;
  localparam int CODE_W = 5;
  localparam int ADDR_W = 2;
  localparam int PAD_W  = BYTE_W - CODE_W;

  localparam int BIT_ACK = 2;
  localparam int BIT_SI  = 3;
  localparam int BIT_STA = 5;
  localparam int BIT_EN  = 6;

  localparam logic [BYTE_W-1:0] FLAG_MASK =
    BYTE_W'((1 << BIT_ACK) | (1 << BIT_SI) | (1 << BIT_STA) | (1 << BIT_EN));

  localparam logic [CODE_W-1:0] IDLE_CODE = '1;

  typedef enum logic [ADDR_W-1:0] {
    A_FSET = 2'd0,
    A_STAT = 2'd1,
    A_DATA = 2'd2,
    A_FCLR = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/serctl_flags.sv
module serctl_flags
  import serctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              si_set_ok,
  input  logic              core_si_set,
  input  logic              core_si_clr,
  output logic [BYTE_W-1:0] flags
);
  logic [BYTE_W-1:0] cpu_set, cpu_clr, core_set, core_clr;

  always_comb begin
    cpu_set = set_we ? (wdata & FLAG_MASK) : '0;
    if (!si_set_ok) cpu_set[BIT_SI] = 1'b0;
    cpu_clr  = clr_we ? (wdata & FLAG_MASK) : '0;
    core_set = '0;
    core_clr = '0;
    core_set[BIT_SI] = core_si_set;
    core_clr[BIT_SI] = core_si_clr;
  end

  for (genvar gi = 0; gi < BYTE_W; gi++) begin : g_bit
    if (FLAG_MASK[gi]) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags[gi] <= 1'b0;
        else if (core_set[gi]) flags[gi] <= 1'b1;
        else if (cpu_clr[gi] || core_clr[gi]) flags[gi] <= 1'b0;
        else if (cpu_set[gi]) flags[gi] <= 1'b1;
      end
    end else begin : g_rsvd
      assign flags[gi] = 1'b0;
    end
  end
endmodule

// File: rtl/serctl_status.sv
module serctl_status
  import serctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              post,
  input  logic [CODE_W-1:0] code,
  output logic [BYTE_W-1:0] stat_byte,
  output logic              is_idle
);
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    code_q <= IDLE_CODE;
    else if (post) code_q <= code;
  end

  assign stat_byte = {code_q, {PAD_W{1'b0}}};
  assign is_idle   = (code_q == IDLE_CODE);
endmodule

// File: rtl/serctl_data.sv
module serctl_data
  import serctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              si,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              shift,
  input  logic              sin,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              sout
);
  logic [BYTE_W-1:0] dat_q, hold_q;
  logic              cpu_wr, do_shift;

  assign cpu_wr   = wr_en && si;
  assign do_shift = shift && !si;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dat_q <= '0;
    else if (cpu_wr)   dat_q <= wdata;
    else if (do_shift) dat_q <= {dat_q[BYTE_W-2:0], sin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hold_q <= '0;
    else if (cpu_wr) hold_q <= wdata;
    else if (si)     hold_q <= dat_q;
  end

  assign rd_byte = si ? dat_q : hold_q;
  assign sout    = dat_q[BYTE_W-1];
endmodule

// File: rtl/serctl_regfile.sv
module serctl_regfile
  import serctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_we,
  input  logic [BYTE_W-1:0] cpu_wdata,
  output logic [BYTE_W-1:0] cpu_rdata,
  input  logic              core_post,
  input  logic [CODE_W-1:0] core_code,
  input  logic              core_shift,
  input  logic              core_sin,
  output logic              core_sout,
  output logic              irq_flag
);
  logic [BYTE_W-1:0] flags, stat_byte, data_byte;
  logic              is_idle, post_busy, post_idle;

  assign post_busy = core_post && (core_code != IDLE_CODE);
  assign post_idle = core_post && (core_code == IDLE_CODE);

  serctl_flags u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_we      (cpu_we && cpu_addr == A_FSET),
    .clr_we      (cpu_we && cpu_addr == A_FCLR),
    .wdata       (cpu_wdata),
    .si_set_ok   (!is_idle),
    .core_si_set (post_busy),
    .core_si_clr (post_idle),
    .flags       (flags)
  );

  serctl_status u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .post      (core_post),
    .code      (core_code),
    .stat_byte (stat_byte),
    .is_idle   (is_idle)
  );

  serctl_data u_data (
    .clk     (clk),
    .rst_n   (rst_n),
    .si      (flags[BIT_SI]),
    .wr_en   (cpu_we && cpu_addr == A_DATA),
    .wdata   (cpu_wdata),
    .shift   (core_shift),
    .sin     (core_sin),
    .rd_byte (data_byte),
    .sout    (core_sout)
  );

  assign irq_flag = flags[BIT_SI];

  always_comb begin
    unique case (cpu_addr)
      A_FSET, A_FCLR: cpu_rdata = flags;
      A_STAT:         cpu_rdata = stat_byte;
      default:        cpu_rdata = data_byte;
    endcase
  end
endmodule

// File: rtl/serctl_checker.sv
module serctl_checker
  import serctl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_we,
  input logic [BYTE_W-1:0] cpu_wdata,
  input logic              core_post,
  input logic [CODE_W-1:0] core_code,
  input logic              irq_flag,
  input logic [BYTE_W-1:0] flags,
  input logic [BYTE_W-1:0] stat_byte,
  input logic [BYTE_W-1:0] dat_q
);
  AST_STAT_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    stat_byte[PAD_W-1:0] == '0); // R5
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (flags & ~FLAG_MASK) == '0); // R4
  AST_IDLE_NO_SI: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_byte[BYTE_W-1:PAD_W] == IDLE_CODE) |-> !irq_flag); // R6
  AST_POST_SETS_SI: assert property (@(posedge clk) disable iff (!rst_n)
    (core_post && core_code != IDLE_CODE) |=> irq_flag); // R7
  AST_CLR_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_addr == A_FCLR && cpu_wdata[BIT_ACK]) |=> !flags[BIT_ACK]); // R3
  AST_DATA_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !(cpu_we && cpu_addr == A_DATA)) |=> $stable(dat_q)); // R9
endmodule

bind serctl_regfile serctl_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_addr  (cpu_addr),
  .cpu_we    (cpu_we),
  .cpu_wdata (cpu_wdata),
  .core_post (core_post),
  .core_code (core_code),
  .irq_flag  (irq_flag),
  .flags     (flags),
  .stat_byte (stat_byte),
  .dat_q     (u_data.dat_q)
);

// File: tb/serctl_regfile_bench.sv
module serctl_regfile_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cpu_addr = '0;
  logic       cpu_we = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic       core_post = 1'b0;
  logic [4:0] core_code = '0;
  logic       core_shift = 1'b0;
  logic       core_sin = 1'b0;
  logic       core_sout;
  logic       irq_flag;
  int         total = 0;
  int         bad = 0;
  logic [7:0] rd;
  localparam logic [7:0] MASK = 8'h6C;

  always #5 clk = ~clk;

  serctl_regfile u_serctl_regfile (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .core_post(core_post),
    .core_code(core_code), .core_shift(core_shift), .core_sin(core_sin),
    .core_sout(core_sout), .irq_flag(irq_flag)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_we = 1'b1; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic rdr(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    cpu_addr = a;
    #1 d = cpu_rdata;
  endtask

  task automatic post(input logic [4:0] c);
    @(negedge clk);
    core_post = 1'b1; core_code = c;
    @(negedge clk);
    core_post = 1'b0;
  endtask

  initial begin
    #1500000;
    bad++; total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    rdr(2'd0, rd); chk(rd == 8'h00, "R1 flags", rd, 8'h00);
    rdr(2'd1, rd); chk(rd == 8'hF8, "R1 status", rd, 8'hF8);
    rdr(2'd2, rd); chk(rd == 8'h00, "R1 data", rd, 8'h00);

    // R2 SI set blocked while idle code shown
    wr(2'd0, 8'h08); rdr(2'd0, rd); chk(rd == 8'h00, "R2 si_idle", rd, 8'h00);

    post(5'd0);
    // R2 / R4 set sweep
    for (int v = 0; v < 256; v++) begin
      wr(2'd3, 8'hFF);
      wr(2'd0, 8'(v));
      rdr(2'd0, rd);
      chk(rd == (8'(v) & MASK), "R2_R4 set", rd, 8'(v) & MASK);
    end
    // R3 / R4 clear sweep
    for (int v = 0; v < 256; v++) begin
      wr(2'd0, 8'hFF);
      wr(2'd3, 8'(v));
      rdr(2'd0, rd);
      chk(rd == (MASK & ~8'(v)), "R3_R4 clr", rd, MASK & ~8'(v));
    end
    // R5 / R6 status sweep
    for (int c = 0; c < 32; c++) begin
      wr(2'd3, 8'hFF);
      post(5'(c));
      rdr(2'd1, rd);
      chk(rd == 8'(c * 8), "R5 status", rd, c * 8);
      chk(irq_flag == (c != 31), "R6 si", irq_flag, c != 31);
    end
    wr(2'd1, 8'h55); rdr(2'd1, rd); chk(rd == 8'hF8, "R5 ro", rd, 8'hF8);

    // R7 core set wins over CPU clear
    @(negedge clk);
    cpu_addr = 2'd3; cpu_we = 1'b1; cpu_wdata = 8'h08;
    core_post = 1'b1; core_code = 5'h08;
    @(negedge clk);
    cpu_we = 1'b0; core_post = 1'b0;
    chk(irq_flag == 1'b1, "R7 priority", irq_flag, 1);

    // R8 data access while SI set
    wr(2'd2, 8'hA5); rdr(2'd2, rd); chk(rd == 8'hA5, "R8 wr_si", rd, 8'hA5);
    // R9 shift ignored while SI set
    @(negedge clk); core_shift = 1'b1; core_sin = 1'b1;
    @(negedge clk); core_shift = 1'b0;
    rdr(2'd2, rd); chk(rd == 8'hA5, "R9 no_shift", rd, 8'hA5);
    // R8 writes ignored while SI clear
    wr(2'd3, 8'h08);
    wr(2'd2, 8'h3C); rdr(2'd2, rd); chk(rd == 8'hA5, "R8 wr_blocked", rd, 8'hA5);
    // R10 shift A5 out, shift 3C in
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      chk(core_sout == 1'((8'hA5 >> i) & 1), "R10 sout", core_sout, (8'hA5 >> i) & 1);
      core_shift = 1'b1; core_sin = 1'((8'h3C >> i) & 1);
      @(negedge clk); core_shift = 1'b0;
      rdr(2'd2, rd); chk(rd == 8'hA5, "R8 hold", rd, 8'hA5);
    end
    post(5'h0A);
    rdr(2'd2, rd); chk(rd == 8'h3C, "R10 rx", rd, 8'h3C);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule